// File: doc/BRIEF.md
# Sector Hamming ECC Engine with Error Locator

This block watches the bytes of one flash sector as they stream past and builds a single-error-correcting parity word over them. Each byte updates a running parity. The update uses the byte's position in the sector and the positions of its set bits. The parity is one line/column code: for every offset address bit and every bit-index bit there is one pair of parities. The pair's even member covers the places where that address bit is 0, and its odd member covers the places where it is 1. When a sector is written, the host pulses init, streams the bytes in encode mode and then reads the 32-bit parity word. It sends out the bytes of that word least-significant first.

When a sector is read back, the host streams the bytes again in decode mode. It then writes the stored parity in two 16-bit halves, low half first. On the high-half write the block forms the syndrome and classifies it into a 2-bit error kind. For a single flipped data bit it also gives the byte offset and the bit index, so that the host can repair the sector buffer itself. A lock input freezes the running parity, so bytes that are not part of the protected data can pass by without being counted.

Top module: `eccCheckerTop`

## Requirements
- R1: A cycle with initPulse high sets eccWord to zero, sets the internal byte offset back to 0 and drops statusValid, all visible after the next clock edge.
- R2: A byte with byteValid high and lockIn low is folded into the parity at the current offset, and the offset then advances. A byte presented while lockIn is high changes neither eccWord nor the offset.
- R3: Pair i occupies eccWord bits 2i (even) and 2i+1 (odd). Pairs 0..2 cover bit-index bits 0..2 and pairs 3..3+ADDR_W-1 cover offset bits 0..ADDR_W-1. A data bit set at offset a, bit b toggles, in each pair, the odd member if the governing address bit is 1 and the even member otherwise. Unused upper bits read 0.
- R4: In encode mode (encodeMode=1), parity-half writes are ignored and statusValid stays low.
- R5: In decode mode, a parWrLo cycle stores parData as stored-parity bits 15:0. A parWrHi cycle supplies bits 31:16.
- R6: In decode mode, statusValid rises one clock after a parWrHi cycle. While it is high, status stays unchanged and further half writes are ignored until the next init.
- R7: Status bits 1:0 carry the error kind: 0 means the syndrome (stored XOR computed) is zero. In that case all other status bits are 0.
- R8: Kind 1 (single correctable) is reported when every pair's two syndrome bits differ and the unused upper syndrome bits are 0. Status bits 17:7 then hold the zero-extended byte offset and bits 6:4 the bit index.
- R9: Kind 3 (parity-field error) is reported when any other syndrome has exactly one set bit.
- R10: Kind 2 (multiple errors) is reported for every other nonzero syndrome.
- R11: Status bits 31:18 and 3:2 are always 0, and bits 17:4 are 0 unless the kind is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initPulse | input | 1 | Clears parity, offset and status |
| lockIn | input | 1 | High freezes parity accumulation |
| encodeMode | input | 1 | 1 = generate parity, 0 = check |
| byteValid | input | 1 | byteData carries a sector byte |
| byteData | input | 8 | Sector byte |
| parWrLo | input | 1 | Write stored parity bits 15:0 |
| parWrHi | input | 1 | Write stored parity bits 31:16 and evaluate |
| parData | input | 16 | Stored parity half |
| eccWord | output | 32 | Running parity word |
| status | output | 32 | Error kind and location |
| statusValid | output | 1 | status holds a verdict |

## Verification
The assertions assume the host does not present a byte in the same cycle as an init. They also assume that once a verdict is out, the host leaves it alone until it sends another init. The stimulus drives init, bytes and parity-half writes only in separate cycles. It always sends the low half before the high half and reaches a new sector only through an init. It writes extra high halves only to test that they are ignored while the verdict holds. Under these assumptions status and statusValid can change only on init or on the high-half write, which is what the checker relies on.

// File: rtl/eccPkg.sv
package eccPkg;

  typedef struct packed {
    logic clear;
    logic accum;
    logic loadLo;
    logic evalHi;
  } eccStrobeT;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_MULTI  = 2'd2,
    ERR_PARITY = 2'd3
  } errKindT;

  localparam int STAT_BIT_LSB = 4;
  localparam int STAT_OFF_LSB = 7;
  localparam int STAT_OFF_W   = 11;
  localparam int WORD_W       = 32;
  localparam int HALF_W       = 16;
  localparam int COL_PAIRS    = 3;

endpackage

// File: rtl/eccControl.sv
module eccControl
  import eccPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      initPulse,
  input  logic      lockIn,
  input  logic      encodeMode,
  input  logic      byteValid,
  input  logic      parWrLo,
  input  logic      parWrHi,
  output eccStrobeT strobes,
  output logic      statusValid
);

  logic validQ;

  // Init dominates; verdict freezes further parity-half writes.
  always_comb begin
    strobes.clear  = initPulse;
    strobes.accum  = byteValid & ~lockIn & ~initPulse;
    strobes.loadLo = parWrLo & ~encodeMode & ~initPulse & ~validQ;
    strobes.evalHi = parWrHi & ~encodeMode & ~initPulse & ~validQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              validQ <= 1'b0;
    else if (strobes.clear) validQ <= 1'b0;
    else if (strobes.evalHi) validQ <= 1'b1;
  end

  assign statusValid = validQ;

endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  eccStrobeT   strobes,
  input  logic [7:0]  byteData,
  input  logic [15:0] parData,
  output logic [31:0] eccWord,
  output logic [31:0] status
);

  localparam int PAIRS = COL_PAIRS + ADDR_W;
  localparam int PW    = 2 * PAIRS;

  logic [ADDR_W-1:0]       byteCnt;
  logic [PW-1:0]           parAcc, parNext;
  logic [HALF_W-1:0]       storedLo;
  logic [COL_PAIRS-1:0]    colEven, colOdd;
  logic                    rowPar;
  logic [WORD_W-1:0]       syn, statusNext, statusQ;
  logic [ADDR_W-1:0]       errOff;
  logic [COL_PAIRS-1:0]    errBit;
  logic [PAIRS-1:0]        pairSplit;
  errKindT                 kind;

  // Column parities: fold the byte's bits by each bit-index bit.
  always_comb begin
    colEven = '0;
    colOdd  = '0;
    for (int j = 0; j < COL_PAIRS; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) != 0) colOdd[j]  = colOdd[j]  ^ byteData[b];
        else                     colEven[j] = colEven[j] ^ byteData[b];
      end
    end
  end

  assign rowPar = ^byteData;

  genvar gi;
  generate
    for (gi = 0; gi < COL_PAIRS; gi++) begin : gCol
      assign parNext[2*gi]   = parAcc[2*gi]   ^ colEven[gi];
      assign parNext[2*gi+1] = parAcc[2*gi+1] ^ colOdd[gi];
    end
    for (gi = 0; gi < ADDR_W; gi++) begin : gRow
      localparam int P = COL_PAIRS + gi;
      assign parNext[2*P]   = parAcc[2*P]   ^ (rowPar & ~byteCnt[gi]);
      assign parNext[2*P+1] = parAcc[2*P+1] ^ (rowPar &  byteCnt[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parAcc  <= '0;
      byteCnt <= '0;
    end else if (strobes.clear) begin
      parAcc  <= '0;
      byteCnt <= '0;
    end else if (strobes.accum) begin
      parAcc  <= parNext;
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               storedLo <= '0;
    else if (strobes.loadLo) storedLo <= parData;
  end

  // Syndrome uses the high half straight from the write cycle.
  assign syn = {parData, storedLo} ^ WORD_W'(parAcc);

  generate
    for (gi = 0; gi < PAIRS; gi++) begin : gSplit
      assign pairSplit[gi] = syn[2*gi] ^ syn[2*gi+1];
    end
    for (gi = 0; gi < COL_PAIRS; gi++) begin : gBit
      assign errBit[gi] = syn[2*gi+1];
    end
    for (gi = 0; gi < ADDR_W; gi++) begin : gOff
      assign errOff[gi] = syn[2*(COL_PAIRS+gi)+1];
    end
  endgenerate

  always_comb begin
    if (syn == '0)
      kind = ERR_NONE;
    else if ((&pairSplit) && ((syn >> PW) == '0))
      kind = ERR_SINGLE;
    else if ($countones(syn) == 1)
      kind = ERR_PARITY;
    else
      kind = ERR_MULTI;
  end

  always_comb begin
    statusNext = '0;
    statusNext[1:0] = kind;
    if (kind == ERR_SINGLE) begin
      statusNext[STAT_BIT_LSB +: COL_PAIRS]  = errBit;
      statusNext[STAT_OFF_LSB +: STAT_OFF_W] = STAT_OFF_W'(errOff);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               statusQ <= '0;
    else if (strobes.clear)  statusQ <= '0;
    else if (strobes.evalHi) statusQ <= statusNext;
  end

  assign eccWord = WORD_W'(parAcc);
  assign status  = statusQ;

endmodule

// File: rtl/eccCheckerTop.sv
module eccCheckerTop
  import eccPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        initPulse,
  input  logic        lockIn,
  input  logic        encodeMode,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        parWrLo,
  input  logic        parWrHi,
  input  logic [15:0] parData,
  output logic [31:0] eccWord,
  output logic [31:0] status,
  output logic        statusValid
);

  eccStrobeT strobes;

  eccControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .initPulse  (initPulse),
    .lockIn     (lockIn),
    .encodeMode (encodeMode),
    .byteValid  (byteValid),
    .parWrLo    (parWrLo),
    .parWrHi    (parWrHi),
    .strobes    (strobes),
    .statusValid(statusValid)
  );

  eccDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .byteData(byteData),
    .parData (parData),
    .eccWord (eccWord),
    .status  (status)
  );

endmodule

// File: rtl/eccCheckerTop_sva.sv
module eccCheckerSva (
  input logic        clk,
  input logic        rstN,
  input logic        initPulse,
  input logic        lockIn,
  input logic        encodeMode,
  input logic        parWrHi,
  input logic [31:0] eccWord,
  input logic [31:0] status,
  input logic        statusValid
);

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |=> (eccWord == 32'd0) && !statusValid);

  assert_lock_freezes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lockIn && !initPulse) |=> $stable(eccWord));

  assert_encode_no_verdict_R4: assert property (@(posedge clk) disable iff (!rstN)
    (encodeMode && !statusValid && !initPulse) |=> !statusValid);

  assert_verdict_after_hi_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusValid) |-> $past(parWrHi && !encodeMode));

  assert_verdict_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && !initPulse) |=> statusValid && $stable(status));

  assert_clean_fields_R11: assert property (@(posedge clk) disable iff (!rstN)
    (status[31:18] == 14'd0) && (status[3:2] == 2'd0));

  assert_location_only_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    (status[1:0] != 2'd1) |-> (status[17:4] == 14'd0));

endmodule

bind eccCheckerTop eccCheckerSva uSva (
  .clk        (clk),
  .rstN       (rstN),
  .initPulse  (initPulse),
  .lockIn     (lockIn),
  .encodeMode (encodeMode),
  .parWrHi    (parWrHi),
  .eccWord    (eccWord),
  .status     (status),
  .statusValid(statusValid)
);

// File: tb/eccCheckerTop_test.sv
module eccCheckerTop_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int SECTOR     = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initPulse = 1'b0, lockIn = 1'b0, encodeMode = 1'b1;
  logic        byteValid = 1'b0, parWrLo = 1'b0, parWrHi = 1'b0;
  logic [7:0]  byteData = '0;
  logic [15:0] parData = '0;
  logic [31:0] eccWord, status;
  logic        statusValid;

  int checks = 0;
  int errors = 0;
  logic [7:0] sec [SECTOR];

  always #(CLK_PERIOD/2) clk = ~clk;

  eccCheckerTop #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .lockIn(lockIn),
    .encodeMode(encodeMode), .byteValid(byteValid), .byteData(byteData),
    .parWrLo(parWrLo), .parWrHi(parWrHi), .parData(parData),
    .eccWord(eccWord), .status(status), .statusValid(statusValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model from R3: each set bit toggles one member of every pair.
  function automatic logic [31:0] bitCode(input int a, input int b);
    logic [31:0] c = '0;
    for (int j = 0; j < 3; j++) c[2*j + ((b >> j) & 1)] = 1'b1;
    for (int k = 0; k < ADDR_W; k++) c[2*(3+k) + ((a >> k) & 1)] = 1'b1;
    return c;
  endfunction

  function automatic logic [31:0] modelParity(input int upto);
    logic [31:0] p = '0;
    for (int a = 0; a < upto; a++)
      for (int b = 0; b < 8; b++)
        if (sec[a][b]) p ^= bitCode(a, b);
    return p;
  endfunction

  task automatic doInit();
    initPulse = 1'b1; @(negedge clk); initPulse = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    byteValid = 1'b1; byteData = d; @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic streamSector(input int fa, input int fb);
    for (int a = 0; a < SECTOR; a++) begin
      logic [7:0] d = sec[a];
      if (a == fa) d[fb] = ~d[fb];
      sendByte(d);
    end
  endtask

  task automatic writeParity(input logic [31:0] w);
    parWrLo = 1'b1; parData = w[15:0]; @(negedge clk); parWrLo = 1'b0;
    parWrHi = 1'b1; parData = w[31:16]; @(negedge clk); parWrHi = 1'b0;
  endtask

  task automatic fillSector(input int seed);
    for (int a = 0; a < SECTOR; a++) sec[a] = 8'((a * 37 + seed * 11 + 5) ^ (seed << 3));
  endtask

  // Decode pass: stream (optionally with one flipped bit), supply stored parity.
  task automatic decodeRun(input int fa, input int fb, input logic [31:0] stored,
                           input string req, input logic [31:0] expStat);
    doInit();
    encodeMode = 1'b0;
    streamSector(fa, fb);
    writeParity(stored);
    check({req, " valid"}, {31'd0, statusValid}, 32'd1);
    check({req, " status"}, status, expStat);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] good;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset eccWord", eccWord, 32'd0);
    check("R1 reset valid", {31'd0, statusValid}, 32'd0);

    // R3 encode over several patterns
    for (int s = 0; s < 4; s++) begin
      fillSector(s);
      doInit();
      encodeMode = 1'b1;
      streamSector(-1, 0);
      check("R3 encode parity", eccWord, modelParity(SECTOR));
    end

    // R2 lock: locked bytes ignored, offset not advanced
    fillSector(7);
    doInit();
    for (int a = 0; a < 5; a++) sendByte(sec[a]);
    check("R2 partial parity", eccWord, modelParity(5));
    good = eccWord;
    lockIn = 1'b1;
    sendByte(8'hFF); sendByte(8'h5A); sendByte(8'h01);
    check("R2 locked unchanged", eccWord, good);
    lockIn = 1'b0;
    for (int a = 5; a < SECTOR; a++) sendByte(sec[a]);
    check("R2 offset kept", eccWord, modelParity(SECTOR));

    // R4 encode-mode writes ignored
    writeParity(32'h1234_5678);
    check("R4 no verdict in encode", {31'd0, statusValid}, 32'd0);

    // R1 init clears
    doInit();
    check("R1 init eccWord", eccWord, 32'd0);

    // R7 clean read, R5 halves, R6 hold
    fillSector(2);
    good = modelParity(SECTOR);
    decodeRun(-1, 0, good, "R7 R5 clean", 32'd0);
    writeParity(good ^ 32'h0000_0030);
    check("R6 hold after extra write", status, 32'd0);
    check("R6 still valid", {31'd0, statusValid}, 32'd1);
    doInit();
    check("R1 init drops valid", {31'd0, statusValid}, 32'd0);

    // R8 exhaustive single-bit sweep
    for (int a = 0; a < SECTOR; a++)
      for (int b = 0; b < 8; b++) begin
        fillSector(a + b);
        good = modelParity(SECTOR);
        decodeRun(a, b, good, "R8 single", (32'(a) << 7) | (32'(b) << 4) | 32'd1);
      end

    // R9 one stored parity bit flipped, every bit position incl. unused
    fillSector(9);
    good = modelParity(SECTOR);
    for (int k = 0; k < 32; k++)
      decodeRun(-1, 0, good ^ (32'd1 << k), "R9 parity field", 32'd3);

    // R10 double data errors
    fillSector(4);
    good = modelParity(SECTOR);
    for (int a = 0; a < SECTOR; a++) begin
      doInit();
      encodeMode = 1'b0;
      for (int i = 0; i < SECTOR; i++) begin
        logic [7:0] d = sec[i];
        if (i == a) d[a % 8] = ~d[a % 8];
        if (i == (a + 3) % SECTOR) d[(a + 1) % 8] = ~d[(a + 1) % 8];
        sendByte(d);
      end
      writeParity(good);
      check("R10 double error", status, 32'd2);
    end
    decodeRun(-1, 0, good ^ 32'h0000_0003, "R10 two parity bits", 32'd2);
    decodeRun(-1, 0, good ^ 32'h8000_0000 ^ bitCode(1, 1), "R10 data plus unused", 32'd2);

    // R11 fields clean after verdicts
    check("R11 upper bits zero", {status[31:18], status[3:2]}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule